// File: doc/BRIEF.md
# SIMD Integer Lane Compare Unit

This block compares two 128-bit vector operands lane by lane and writes a mask into each destination lane. A lane whose condition holds becomes all ones across its width. A lane whose condition fails becomes all zeros. The lane width comes from a 2-bit size code, and a 3-bit opcode selects the condition. The block offers equality, signed and unsigned orderings, sign tests against zero, and a bit-test.

A compare-with-zero select replaces the second operand with the constant zero in every lane. A scalar select limits the work to lane 0 and clears every other bit. A half-register select clears the upper 64 bits, which suits 64-bit register forms. The result is registered and comes with a valid flag one cycle after the input strobe. Decode, register file access and flag updates belong to the surrounding pipeline.

Top module: `simd_lane_cmp`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. Reset clears `out_valid` and `result` to zero.
- R2: The lane width is 8 << `elem_size` bits (size 0..3 gives 8, 16, 32 or 64 bits). Each computed lane is all ones when its condition is true and all zeros when it is false.
- R3: Opcode values are 0 equal, 1 signed greater-or-equal, 2 signed greater, 3 unsigned higher and 4 unsigned higher-or-same, each comparing operand A against operand B. Opcodes 1 and 2 treat lanes as two's complement; opcodes 3 and 4 treat them as unsigned.
- R4: When `use_zero` is 1, the second operand of every lane is zero, whatever `op_b` holds.
- R5: Opcode 5 is true when the signed lane of A is at most zero. Opcode 6 is true when it is below zero. `op_b` has no effect on either.
- R6: Opcode 7 is true when the bitwise AND of the A lane and the second operand lane is nonzero.
- R7: When `scalar_mode` is 1, only lane 0 (bits 0 to lane width minus 1) is computed, and all higher result bits are zero.
- R8: When `half_reg` is 1 in vector mode, result bits 127:64 are zero, and only lanes below bit 64 are computed.
- R9: In a cycle with `in_valid` low, `result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_a | input | 128 | First vector operand |
| op_b | input | 128 | Second vector operand |
| use_zero | input | 1 | Replace the second operand with zero |
| opcode | input | 3 | Condition select (see R3, R5, R6) |
| elem_size | input | 2 | Lane size code |
| scalar_mode | input | 1 | Compute lane 0 only |
| half_reg | input | 1 | 64-bit register form, clears bits 127:64 |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Lane mask vector |

## Verification
The sign boundary is the hardest case to reach. The values 0x80..0 and 0x7F..F order one way as signed numbers and the other way as unsigned numbers, and random operands seldom land there for the wide lanes. The stimulus therefore drives these patterns directly at every lane size, both with opcode pairs that share operands and with the zero forms. It then runs random operands whose lanes are drawn from a small set of boundary values, so that equal lanes, sign flips and zero lanes appear often across all sizes, modes and opcodes.

// File: rtl/simd_cmp_pkg.sv
package simd_cmp_pkg;
   typedef enum logic [2:0] {
      CMP_EQ  = 3'd0,
      CMP_SGE = 3'd1,
      CMP_SGT = 3'd2,
      CMP_UGT = 3'd3,
      CMP_UGE = 3'd4,
      CMP_LEZ = 3'd5,
      CMP_LTZ = 3'd6,
      CMP_TST = 3'd7
   } cmp_op_e;

   localparam int unsigned SIZE_CODES = 4;
   localparam int unsigned BYTE_W     = 8;
endpackage

// File: rtl/cmp_lane.sv
module cmp_lane
   import simd_cmp_pkg::*;
#(
   parameter int unsigned LANE_W = 8
) (
   input  logic [LANE_W-1:0] a,
   input  logic [LANE_W-1:0] b,
   input  logic              zero_b,
   input  cmp_op_e           op,
   output logic              hit
);
   logic [LANE_W-1:0] bv;
   logic signed [LANE_W-1:0] sa, sb;
   logic signed [LANE_W-1:0] zs;

   assign bv = zero_b ? '0 : b;
   assign sa = a;
   assign sb = bv;
   assign zs = '0;

   always_comb begin
      unique case (op)
         CMP_EQ:  hit = (a == bv);
         CMP_SGE: hit = (sa >= sb);
         CMP_SGT: hit = (sa > sb);
         CMP_UGT: hit = (a > bv);
         CMP_UGE: hit = (a >= bv);
         CMP_LEZ: hit = !(sa > zs);
         CMP_LTZ: hit = (zs > sa);
         CMP_TST: hit = |(a & bv);
         default: hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/cmp_size_slice.sv
module cmp_size_slice
   import simd_cmp_pkg::*;
#(
   parameter int unsigned VEC_W  = 128,
   parameter int unsigned LANE_W = 8
) (
   input  logic [VEC_W-1:0] a,
   input  logic [VEC_W-1:0] b,
   input  logic             zero_b,
   input  cmp_op_e          op,
   output logic [VEC_W-1:0] mask
);
   localparam int unsigned LANES = VEC_W / LANE_W;

   if (VEC_W % LANE_W != 0) begin : g_bad_lane
      $error("cmp_size_slice: VEC_W must be a multiple of LANE_W");
   end

   for (genvar li = 0; li < LANES; li++) begin : g_lane
      logic hit;
      cmp_lane #(.LANE_W(LANE_W)) u_lane (
         .a      (a[li*LANE_W +: LANE_W]),
         .b      (b[li*LANE_W +: LANE_W]),
         .zero_b (zero_b),
         .op     (op),
         .hit    (hit)
      );
      assign mask[li*LANE_W +: LANE_W] = {LANE_W{hit}};
   end
endmodule

// File: rtl/lane_keep.sv
module lane_keep
   import simd_cmp_pkg::*;
#(
   parameter int unsigned VEC_W  = 128,
   parameter int unsigned HALF_W = 64
) (
   input  logic [1:0]       size,
   input  logic             scalar,
   input  logic             half,
   output logic [VEC_W-1:0] keep
);
   if (HALF_W >= VEC_W || HALF_W < (BYTE_W << (SIZE_CODES-1))) begin : g_bad_half
      $error("lane_keep: HALF_W must hold one widest lane and be below VEC_W");
   end

   logic [7:0] lane_bits;
   assign lane_bits = 8'(BYTE_W << size);

   always_comb begin
      for (int i = 0; i < VEC_W; i++) begin
         if (scalar)
            keep[i] = (i < int'(lane_bits));
         else if (half)
            keep[i] = (i < HALF_W);
         else
            keep[i] = 1'b1;
      end
   end
endmodule

// File: rtl/simd_lane_cmp.sv
module simd_lane_cmp
   import simd_cmp_pkg::*;
#(
   parameter int unsigned VEC_W  = 128,
   parameter int unsigned HALF_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [VEC_W-1:0] op_a,
   input  logic [VEC_W-1:0] op_b,
   input  logic             use_zero,
   input  logic [2:0]       opcode,
   input  logic [1:0]       elem_size,
   input  logic             scalar_mode,
   input  logic             half_reg,
   output logic             out_valid,
   output logic [VEC_W-1:0] result
);
   localparam int unsigned WIDEST = BYTE_W << (SIZE_CODES-1);
   localparam int unsigned BYTES  = VEC_W / BYTE_W;

   if (VEC_W % WIDEST != 0) begin : g_bad_vec
      $error("simd_lane_cmp: VEC_W must be a multiple of the widest lane");
   end

   cmp_op_e op;
   assign op = cmp_op_e'(opcode);

   logic [VEC_W-1:0] per_size [SIZE_CODES];

   for (genvar si = 0; si < SIZE_CODES; si++) begin : g_size
      cmp_size_slice #(.VEC_W(VEC_W), .LANE_W(BYTE_W << si)) u_slice (
         .a      (op_a),
         .b      (op_b),
         .zero_b (use_zero),
         .op     (op),
         .mask   (per_size[si])
      );
   end

   logic [VEC_W-1:0] keep;
   lane_keep #(.VEC_W(VEC_W), .HALF_W(HALF_W)) u_keep (
      .size   (elem_size),
      .scalar (scalar_mode),
      .half   (half_reg),
      .keep   (keep)
   );

   logic [VEC_W-1:0] next_res;
   assign next_res = per_size[elem_size] & keep;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid)
            result <= next_res;
      end
   end

   // R1: one-cycle latency for the valid strobe
   assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_valid_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R2: every byte of a result is uniform, as all lanes are whole bytes
   for (genvar bi = 0; bi < BYTES; bi++) begin : g_byte_chk
      assert_lane_uniform_R2: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> (result[bi*8 +: 8] == 8'h00 || result[bi*8 +: 8] == 8'hFF));
   end

   // R3: a lane always equals itself
   assert_eq_self_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode == 3'd0 && !use_zero && op_a == op_b && !scalar_mode && !half_reg)
      |=> (result == {VEC_W{1'b1}}));

   // R6: bit-test against zero never hits
   assert_tst_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode == 3'd7 && use_zero) |=> (result == '0));

   // R7: scalar form clears everything above the widest lane
   assert_scalar_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && scalar_mode) |=> (result[VEC_W-1:WIDEST] == '0));

   // R8: half-register form clears the upper half
   assert_upper_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && half_reg) |=> (result[VEC_W-1:HALF_W] == '0));

   // R9: result holds without a strobe
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));
endmodule

// File: tb/tb_simd_lane_cmp.sv
module tb_simd_lane_cmp;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [127:0] op_a = '0, op_b = '0;
   logic         use_zero = 1'b0;
   logic [2:0]   opcode = '0;
   logic [1:0]   elem_size = '0;
   logic         scalar_mode = 1'b0, half_reg = 1'b0;
   logic         out_valid;
   logic [127:0] result;

   int checks = 0, fails = 0;
   logic [127:0] last_res = '0;

   always #2 clk = ~clk;

   simd_lane_cmp dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
      .use_zero(use_zero), .opcode(opcode), .elem_size(elem_size),
      .scalar_mode(scalar_mode), .half_reg(half_reg),
      .out_valid(out_valid), .result(result)
   );

   function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
         input logic uz, input int op, input int sz, input logic sc, input logic hf);
      logic [127:0] r = '0;
      int w = 8 << sz;
      int n = sc ? 1 : (hf ? 64 / w : 128 / w);
      for (int l = 0; l < n; l++) begin
         logic [63:0] ua = '0, ub = '0;
         logic signed [63:0] sa, sb;
         logic hit;
         for (int k = 0; k < w; k++) begin
            ua[k] = a[l*w+k];
            ub[k] = uz ? 1'b0 : b[l*w+k];
         end
         sa = ua; sb = ub;
         for (int k = w; k < 64; k++) begin
            sa[k] = ua[w-1];
            sb[k] = ub[w-1];
         end
         case (op)
            0: hit = (sa == sb);
            1: hit = (sa >= sb);
            2: hit = (sa > sb);
            3: hit = (ua > ub);
            4: hit = (ua >= ub);
            5: hit = (sa <= 0);
            6: hit = (sa < 0);
            default: hit = ((ua & ub) != 0);
         endcase
         if (hit) for (int k = 0; k < w; k++) r[l*w+k] = 1'b1;
      end
      return r;
   endfunction

   task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Drives one cycle at the falling edge and checks it at the next falling edge.
   task automatic step(input string tag, input logic v, input logic [127:0] a,
         input logic [127:0] b, input logic uz, input int op, input int sz,
         input logic sc, input logic hf);
      logic [127:0] exp;
      in_valid = v; op_a = a; op_b = b; use_zero = uz; opcode = 3'(op);
      elem_size = 2'(sz); scalar_mode = sc; half_reg = hf;
      exp = v ? model(a, b, uz, op, sz, sc, hf) : last_res;
      @(negedge clk);
      check({tag, " valid(R1)"}, {127'd0, out_valid}, {127'd0, v});
      check(tag, result, exp);
      last_res = exp;
   endtask

   function automatic logic [127:0] fill(input logic [63:0] v, input int sz);
      logic [127:0] r;
      int w = 8 << sz;
      for (int i = 0; i < 128; i++) r[i] = v[i % w];
      return r;
   endfunction

   function automatic logic [63:0] pick(input int s);
      case (s % 8)
         0: return 64'h0;
         1: return 64'hFFFF_FFFF_FFFF_FFFF;
         2: return 64'h8080_8080_8080_8080;
         3: return 64'h7F7F_7F7F_7F7F_7F7F;
         4: return 64'h0000_0001_0000_0001;
         5: return 64'h8000_0000_0000_0000;
         6: return 64'h7FFF_FFFF_FFFF_FFFF;
         default: return {$urandom, $urandom};
      endcase
   endfunction

   initial begin
      fork
         begin
            repeat (100000) @(posedge clk);
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
         end
      join_none

      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 reset valid", {127'd0, out_valid}, 128'd0);
      check("R1 reset result", result, 128'd0);
      rst_n = 1'b1;

      // R2, R3: sign boundary at every size
      for (int sz = 0; sz < 4; sz++) begin
         logic [63:0] hi = 64'h1 << ((8 << sz) - 1);
         logic [63:0] lo = hi - 1;
         for (int op = 0; op < 5; op++) begin
            step("R3 boundary", 1'b1, fill(hi, sz), fill(lo, sz), 1'b0, op, sz, 1'b0, 1'b0);
            step("R2 boundary swap", 1'b1, fill(lo, sz), fill(hi, sz), 1'b0, op, sz, 1'b0, 1'b0);
         end
         // R5: b ignored for zero forms
         step("R5 lez", 1'b1, fill(hi, sz), fill(lo, sz), 1'b0, 5, sz, 1'b0, 1'b0);
         step("R5 lez zero", 1'b1, 128'd0, ~128'd0, 1'b0, 5, sz, 1'b0, 1'b0);
         step("R5 ltz", 1'b1, fill(lo, sz), fill(hi, sz), 1'b0, 6, sz, 1'b0, 1'b0);
         // R6: bit-test
         step("R6 tst", 1'b1, fill(64'h0F0F_0000_F000_0101, sz), fill(64'h0101_FFFF_0F00_1010, sz), 1'b0, 7, sz, 1'b0, 1'b0);
         // R4: zero operand
         step("R4 zero eq", 1'b1, {64'd0, 64'h0100_0000_0000_0000}, ~128'd0, 1'b1, 0, sz, 1'b0, 1'b0);
         step("R4 zero tst", 1'b1, ~128'd0, ~128'd0, 1'b1, 7, sz, 1'b0, 1'b0);
         // R7: scalar
         step("R7 scalar", 1'b1, ~128'd0, ~128'd0, 1'b0, 0, sz, 1'b1, 1'b0);
         // R8: half register
         step("R8 half", 1'b1, ~128'd0, ~128'd0, 1'b0, 4, sz, 1'b0, 1'b1);
         // R9: hold
         step("R9 hold", 1'b0, 128'd0, 128'd0, 1'b0, 1, sz, 1'b0, 1'b0);
         step("R9 hold2", 1'b0, ~128'd0, 128'd5, 1'b1, 7, sz, 1'b1, 1'b0);
      end

      // R3: random boundary-rich operands over all controls
      for (int i = 0; i < 600; i++) begin
         logic [127:0] a = {pick($urandom), pick($urandom)};
         logic [127:0] b = ($urandom % 4 == 0) ? a : {pick($urandom), pick($urandom)};
         step("R3 random", ($urandom % 5) != 0, a, b, ($urandom % 4) == 0,
              int'($urandom % 8), int'($urandom % 4), ($urandom % 4) == 0, ($urandom % 3) == 0);
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule